// File: doc/BRIEF.md
# Link Delay Tuning Controller

This synchronous controller keeps an on-chip link clock matched to the real settling time of the link it drives. It launches a test bit across the link and drives a digital code into a variable delay element that shifts the capture instant. A short cascade of capture registers then samples the received bit at successively later moments. While the link is healthy the controller sits in a monitoring loop, probing with the delay code at zero and classifying where the new bit first appears.

When a probe shows the link running too slow or too fast, the controller switches to tuning. It sweeps the delay code upward one step at a time to find the first code at which every capture register holds the new bit. From there it sweeps downward to find the last code at which the earliest register still holds the old bit. The difference between the two codes is the slack. The controller nudges the oscillator code by one step, or moves the divider code and recentres the oscillator when the oscillator code is at a limit. It pulses a done flag and returns to monitoring.

The analog delay line, the oscillator, the divider and the link are outside this block. They appear only as code outputs and as the sampled capture inputs.

Top module: `link_tune_ctrl`

## Requirements
- R1: While reset is held and after it is released, the delay code is 0, the oscillator code is half its range (512 for 10 bits), the divider code is 1, and done, tuning and slack are 0.
- R2: In monitoring the delay code is 0. A probe is well tuned when capture register 0 holds the old bit and register 1 holds the new bit. A well-tuned probe keeps the controller in monitoring with no code change and no done pulse. A bit is "new" when it equals the tx_bit output and "old" when it differs from it.
- R3: A probe that is not well tuned raises tuning. Tuning stays high until the frequency update, and it falls at the same edge where done rises for exactly one cycle.
- R4: The end code is the lowest delay code at which all capture registers hold the new bit. The start code is the highest code, at or below the end code, at which register 0 holds the old bit. The slack output equals end minus start.
- R5: Each sweep moves the delay code by one per step. Every probe toggles tx_bit and samples only after settle_cycles further cycles, so successive steps are settle_cycles+1 cycles apart.
- R6: A too-slow result (register 0 old, register 1 old at code 0) raises the oscillator code by one.
- R7: A too-fast result (register 0 new at code 0) lowers the oscillator code by one only when slack is greater than guard_margin. Otherwise the codes are unchanged, but done still pulses.
- R8: A raise with the oscillator code at its maximum instead adds one to the divider code and sets the oscillator code to mid-range.
- R9: A lowering with the oscillator code at 0 instead subtracts one from the divider code and sets the oscillator code to mid-range.
- R10: The divider code stays between 1 and its maximum. At either divider limit, a step that would pass the oscillator limit leaves both codes unchanged.
- R11: If no delay code up to the maximum shows all registers new, the end code is the maximum. If register 0 is new at every code down to 0, the start code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| settle_cycles | input | SET_W | Wait between a probe launch and its sample |
| guard_margin | input | DLY_W | Slack that a too-fast result must exceed to lower the oscillator code |
| cap_q | input | TAPS | Capture register outputs, bit 0 sampled earliest |
| tx_bit | output | 1 | Test bit driven onto the link, toggled per probe |
| dly_code | output | DLY_W | Variable delay element code |
| osc_code | output | OSC_W | Oscillator code |
| div_code | output | DIV_W | Clock divider code |
| slack | output | DLY_W | Slack from the latest tuning pass |
| tuning | output | 1 | High while a tuning pass is in progress |
| done | output | 1 | One-cycle pulse when a pass completes |

## Verification
The bench builds the controller with a 4-bit oscillator code and a 3-bit divider code, and keeps the delay code at its 10-bit default. At that size a few dozen passes walk the oscillator code across its full range, so both divider limits and the recentring on each side can be reached. The full 10-bit delay sweep is kept, so the case where no end code is found runs over all 1024 codes. Settle waits of 1 and 4 cycles are both used to confirm the spacing of the sweep steps.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

  typedef enum logic [2:0] {
    ST_MONITOR,
    ST_SEEK_END,
    ST_SEEK_START,
    ST_SLACK,
    ST_ADJUST
  } tune_state_t;

  typedef enum logic [1:0] {
    CAP_WELL,
    CAP_SLOW,
    CAP_FAST
  } cap_class_t;

  typedef struct packed {
    logic up;
    logic down;
  } freq_req_t;

endpackage

// File: rtl/ltc_settle_timer.sv
module ltc_settle_timer #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SET_W-1:0] limit,
  output logic             settled
);

  localparam logic [SET_W-1:0] STEP = SET_W'(1);

  logic [SET_W-1:0] cnt_q;

  // settled also holds if limit drops below the running count
  assign settled = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (!settled) begin
      cnt_q <= cnt_q + STEP;
    end
  end

endmodule

// File: rtl/ltc_capture_classifier.sv
module ltc_capture_classifier
  import ltc_pkg::*;
#(
  parameter int TAPS     = 3,
  parameter int INTENDED = 1
) (
  input  logic [TAPS-1:0] cap_q,
  input  logic            tx_bit,
  output logic            all_new,
  output logic            head_old,
  output cap_class_t      cls
);

  logic [TAPS-1:0]   fresh;
  logic [INTENDED:0] early_chain;

  // a register is fresh when it already carries the launched bit
  for (genvar k = 0; k < TAPS; k++) begin : g_fresh
    assign fresh[k] = (cap_q[k] == tx_bit);
  end

  assign early_chain[0] = 1'b0;
  for (genvar k = 0; k < INTENDED; k++) begin : g_early
    assign early_chain[k+1] = early_chain[k] | fresh[k];
  end

  function automatic cap_class_t classify(input logic early, input logic on_time);
    if (early)        return CAP_FAST;
    else if (!on_time) return CAP_SLOW;
    else              return CAP_WELL;
  endfunction

  assign all_new  = &fresh;
  assign head_old = ~fresh[0];
  assign cls      = classify(early_chain[INTENDED], fresh[INTENDED]);

endmodule

// File: rtl/ltc_freq_step.sv
module ltc_freq_step
  import ltc_pkg::*;
#(
  parameter int OSC_W = 10,
  parameter int DIV_W = 8
) (
  input  logic [OSC_W-1:0] osc_cur,
  input  logic [DIV_W-1:0] div_cur,
  input  freq_req_t        req,
  output logic [OSC_W-1:0] osc_nxt,
  output logic [DIV_W-1:0] div_nxt
);

  localparam logic [OSC_W-1:0] OSC_MAX = {OSC_W{1'b1}};
  localparam logic [OSC_W-1:0] OSC_MID = OSC_W'(1) << (OSC_W - 1);
  localparam logic [OSC_W-1:0] OSC_ONE = OSC_W'(1);
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  // oscillator moves first; divider only takes over at the oscillator ends
  always_comb begin
    osc_nxt = osc_cur;
    div_nxt = div_cur;
    if (req.up) begin
      if (osc_cur != OSC_MAX) begin
        osc_nxt = osc_cur + OSC_ONE;
      end else if (div_cur != DIV_MAX) begin
        div_nxt = div_cur + DIV_ONE;
        osc_nxt = OSC_MID;
      end
    end else if (req.down) begin
      if (osc_cur != '0) begin
        osc_nxt = osc_cur - OSC_ONE;
      end else if (div_cur > DIV_ONE) begin
        div_nxt = div_cur - DIV_ONE;
        osc_nxt = OSC_MID;
      end
    end
  end

endmodule

// File: rtl/link_tune_ctrl.sv
module link_tune_ctrl
  import ltc_pkg::*;
#(
  parameter int DLY_W    = 10,
  parameter int OSC_W    = 10,
  parameter int DIV_W    = 8,
  parameter int SET_W    = 8,
  parameter int TAPS     = 3,
  parameter int INTENDED = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] settle_cycles,
  input  logic [DLY_W-1:0] guard_margin,
  input  logic [TAPS-1:0]  cap_q,
  output logic             tx_bit,
  output logic [DLY_W-1:0] dly_code,
  output logic [OSC_W-1:0] osc_code,
  output logic [DIV_W-1:0] div_code,
  output logic [DLY_W-1:0] slack,
  output logic             tuning,
  output logic             done
);

  localparam logic [DLY_W-1:0] DLY_MAX   = {DLY_W{1'b1}};
  localparam logic [DLY_W-1:0] DLY_ONE   = DLY_W'(1);
  localparam logic [OSC_W-1:0] OSC_RESET = OSC_W'(1) << (OSC_W - 1);
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(1);

  function automatic logic [DLY_W-1:0] span(input logic [DLY_W-1:0] hi,
                                            input logic [DLY_W-1:0] lo);
    return hi - lo;
  endfunction

  tune_state_t      state_q, state_d;
  cap_class_t       cls_q, cls_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [DLY_W-1:0] end_q, end_d;
  logic [DLY_W-1:0] start_q, start_d;
  logic [DLY_W-1:0] slack_q, slack_d;
  logic [OSC_W-1:0] osc_q, osc_nxt;
  logic [DIV_W-1:0] div_q, div_nxt;
  logic             tx_q, done_q;

  // named events for the checker
  logic       settled;
  logic       probe_sample;
  logic       launch;
  logic       adjust_now;
  logic       all_new, head_old;
  cap_class_t cls_now;
  freq_req_t  req;

  ltc_settle_timer #(.SET_W(SET_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (launch),
    .limit   (settle_cycles),
    .settled (settled)
  );

  ltc_capture_classifier #(.TAPS(TAPS), .INTENDED(INTENDED)) u_class (
    .cap_q    (cap_q),
    .tx_bit   (tx_q),
    .all_new  (all_new),
    .head_old (head_old),
    .cls      (cls_now)
  );

  assign adjust_now = (state_q == ST_ADJUST);
  assign req.up     = adjust_now && (cls_q == CAP_SLOW);
  assign req.down   = adjust_now && (cls_q == CAP_FAST) && (slack_q > guard_margin);

  ltc_freq_step #(.OSC_W(OSC_W), .DIV_W(DIV_W)) u_step (
    .osc_cur (osc_q),
    .div_cur (div_q),
    .req     (req),
    .osc_nxt (osc_nxt),
    .div_nxt (div_nxt)
  );

  assign probe_sample = settled &&
                        (state_q == ST_MONITOR || state_q == ST_SEEK_END ||
                         state_q == ST_SEEK_START);

  always_comb begin
    state_d = state_q;
    cls_d   = cls_q;
    dly_d   = dly_q;
    end_d   = end_q;
    start_d = start_q;
    slack_d = slack_q;
    launch  = 1'b0;
    unique case (state_q)
      ST_MONITOR: begin
        if (probe_sample) begin
          launch = 1'b1;
          if (cls_now != CAP_WELL) begin
            cls_d   = cls_now;
            dly_d   = '0;
            state_d = ST_SEEK_END;
          end
        end
      end
      ST_SEEK_END: begin
        if (probe_sample) begin
          launch = 1'b1;
          if (all_new) begin
            end_d   = dly_q;
            state_d = ST_SEEK_START;
          end else if (dly_q == DLY_MAX) begin
            end_d   = DLY_MAX;
            state_d = ST_SEEK_START;
          end else begin
            dly_d = dly_q + DLY_ONE;
          end
        end
      end
      ST_SEEK_START: begin
        if (probe_sample) begin
          if (head_old) begin
            start_d = dly_q;
            state_d = ST_SLACK;
          end else if (dly_q == '0) begin
            start_d = '0;
            state_d = ST_SLACK;
          end else begin
            launch = 1'b1;
            dly_d  = dly_q - DLY_ONE;
          end
        end
      end
      ST_SLACK: begin
        slack_d = span(end_q, start_q);
        state_d = ST_ADJUST;
      end
      ST_ADJUST: begin
        launch  = 1'b1;
        dly_d   = '0;
        state_d = ST_MONITOR;
      end
      default: begin
        state_d = ST_MONITOR;
        dly_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_MONITOR;
      cls_q   <= CAP_WELL;
      dly_q   <= '0;
      end_q   <= '0;
      start_q <= '0;
      slack_q <= '0;
      osc_q   <= OSC_RESET;
      div_q   <= DIV_RESET;
      tx_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cls_q   <= cls_d;
      dly_q   <= dly_d;
      end_q   <= end_d;
      start_q <= start_d;
      slack_q <= slack_d;
      done_q  <= adjust_now;
      if (launch) tx_q <= ~tx_q;
      if (adjust_now) begin
        osc_q <= osc_nxt;
        div_q <= div_nxt;
      end
    end
  end

  assign tx_bit   = tx_q;
  assign dly_code = dly_q;
  assign osc_code = osc_q;
  assign div_code = div_q;
  assign slack    = slack_q;
  assign tuning   = (state_q != ST_MONITOR);
  assign done     = done_q;

endmodule

// File: rtl/ltc_checker.sv
module ltc_checker #(
  parameter int DLY_W = 10,
  parameter int OSC_W = 10,
  parameter int DIV_W = 8,
  parameter int SET_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tuning,
  input logic             done,
  input logic [DLY_W-1:0] dly_code,
  input logic [OSC_W-1:0] osc_code,
  input logic [DIV_W-1:0] div_code,
  input logic             probe_sample,
  input logic             launch,
  input logic [SET_W-1:0] settle_cycles
);

  localparam logic [DLY_W-1:0] D_ONE  = DLY_W'(1);
  localparam logic [OSC_W-1:0] O_MID  = OSC_W'(1) << (OSC_W - 1);
  localparam logic [DIV_W-1:0] V_ONE  = DIV_W'(1);
  localparam logic [15:0]      W_ONE  = 16'd1;

  logic [15:0] since_launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_launch <= '0;
    else if (launch)             since_launch <= '0;
    else if (since_launch != '1) since_launch <= since_launch + W_ONE;
  end

  a_r1_reset_codes: assert property (@(posedge clk)
    !rst_n |=> (dly_code == '0 && osc_code == O_MID && div_code == V_ONE && !done));

  a_r2_monitor_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tuning |-> dly_code == '0);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_tuning_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tuning) |-> done);

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tuning && $past(tuning) && !$stable(dly_code)) |->
      (dly_code == $past(dly_code) + D_ONE || dly_code == $past(dly_code) - D_ONE));

  a_r5_settle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    probe_sample |-> since_launch >= 16'(settle_cycles));

  a_r8_codes_move_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(osc_code) || !$stable(div_code)) |-> done);

  a_r10_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    div_code != '0);

endmodule

bind link_tune_ctrl ltc_checker #(
  .DLY_W(DLY_W), .OSC_W(OSC_W), .DIV_W(DIV_W), .SET_W(SET_W)
) u_ltc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .tuning        (tuning),
  .done          (done),
  .dly_code      (dly_code),
  .osc_code      (osc_code),
  .div_code      (div_code),
  .probe_sample  (probe_sample),
  .launch        (launch),
  .settle_cycles (settle_cycles)
);

// File: tb/link_tune_ctrl_bench.sv
`timescale 1ns/1ps
module link_tune_ctrl_bench;

  localparam int DW = 10;
  localparam int OW = 4;
  localparam int VW = 3;
  localparam int SW = 8;
  localparam int OMAX = (1 << OW) - 1;
  localparam int OMID = 1 << (OW - 1);
  localparam int VMAX = (1 << VW) - 1;
  localparam int DMAX = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] settle_cycles = 8'd1;
  logic [DW-1:0] guard_margin = '0;
  logic [2:0]    cap_q;
  logic          tx_bit, tuning, done;
  logic [DW-1:0] dly_code, slack;
  logic [OW-1:0] osc_code;
  logic [VW-1:0] div_code;

  int t0 = 5, t1 = 0, t2 = 0;
  int n_vec = 0, n_bad = 0, cyc = 0;
  int e_osc = OMID, e_div = 1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // link model: register k shows the launched bit once the delay code reaches its threshold
  assign cap_q[0] = (int'(dly_code) >= t0) ? tx_bit : ~tx_bit;
  assign cap_q[1] = (int'(dly_code) >= t1) ? tx_bit : ~tx_bit;
  assign cap_q[2] = (int'(dly_code) >= t2) ? tx_bit : ~tx_bit;

  link_tune_ctrl #(.DLY_W(DW), .OSC_W(OW), .DIV_W(VW), .SET_W(SW)) u_link_tune_ctrl (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles), .guard_margin(guard_margin),
    .cap_q(cap_q), .tx_bit(tx_bit), .dly_code(dly_code), .osc_code(osc_code),
    .div_code(div_code), .slack(slack), .tuning(tuning), .done(done)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      chk("watchdog", 1'b0, cyc, 150000);
      finish_run();
    end
  end

  // expected code update, written as a target value then folded into range
  task automatic predict(input bit up, input bit down);
    int o;
    o = e_osc + (up ? 1 : 0) - (down ? 1 : 0);
    if (o > OMAX) begin
      if (e_div < VMAX) begin e_div++; e_osc = OMID; end
    end else if (o < 0) begin
      if (e_div > 1) begin e_div--; e_osc = OMID; end
    end else begin
      e_osc = o;
    end
  endtask

  // one tuning pass: program the link, wait for done, compare every result
  task automatic run_pass(input string tag, input int a, input int b, input int c,
                          input int guard, input bit check_steps);
    int end_e, start_e, slack_e, waited, last_up, prev_dly, step_gap;
    bit fast, slow, saw_tuning, gap_ok, have_gap;
    t0 = a; t1 = b; t2 = c;
    guard_margin = DW'(guard);
    fast = (a == 0);
    slow = !fast && (b != 0);
    end_e = a; if (b > end_e) end_e = b; if (c > end_e) end_e = c;
    if (end_e > DMAX) end_e = DMAX;
    start_e = (a == 0) ? 0 : a - 1;
    slack_e = end_e - start_e;
    waited = 0; last_up = -1; prev_dly = int'(dly_code);
    saw_tuning = 0; gap_ok = 1; have_gap = 0; step_gap = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (tuning) saw_tuning = 1;
      if (int'(dly_code) == prev_dly + 1) begin
        if (last_up >= 0) begin
          step_gap = waited - last_up;
          have_gap = 1;
          if (step_gap != int'(settle_cycles) + 1) gap_ok = 0;
        end
        last_up = waited;
      end else if (int'(dly_code) != prev_dly) begin
        last_up = -1;
      end
      prev_dly = int'(dly_code);
    end
    predict(slow, fast && (slack_e > guard));
    chk({tag, " R3 done"}, done === 1'b1, done, 1);
    chk({tag, " R3 tuning seen"}, saw_tuning, saw_tuning, 1);
    chk({tag, " R3 tuning low at done"}, tuning === 1'b0, tuning, 0);
    chk({tag, " R4 slack"}, int'(slack) == slack_e, slack, slack_e);
    chk({tag, " R6 osc"}, int'(osc_code) == e_osc, osc_code, e_osc);
    chk({tag, " R10 div"}, int'(div_code) == e_div, div_code, e_div);
    if (check_steps)
      chk({tag, " R5 step spacing"}, have_gap && gap_ok, step_gap, int'(settle_cycles) + 1);
    t0 = 5; t1 = 0; t2 = 0;  // return the link to a well-tuned state
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, done === 1'b0, done, 0);
  endtask

  task automatic test_reset();
    chk("R1 dly", dly_code == '0, dly_code, 0);
    chk("R1 osc", int'(osc_code) == OMID, osc_code, OMID);
    chk("R1 div", int'(div_code) == 1, div_code, 1);
    chk("R1 flags", !done && !tuning && slack == '0, {done, tuning}, 0);
  endtask

  task automatic test_well_tuned();
    bit moved;
    int o, d;
    moved = 0; o = int'(osc_code); d = int'(div_code);
    t0 = 5; t1 = 0; t2 = 0;
    repeat (200) begin
      @(negedge clk);
      if (tuning || done || dly_code != '0) moved = 1;
    end
    chk("R2 stays monitoring", !moved, moved, 0);
    chk("R2 codes held", int'(osc_code) == o && int'(div_code) == d, osc_code, o);
  endtask

  task automatic test_slow_and_fast();
    run_pass("slow", 3, 6, 9, 0, 1);
    run_pass("R7 fast over guard", 0, 4, 12, 5, 1);
    run_pass("R7 fast within guard", 0, 2, 4, 5, 0);
    settle_cycles = 8'd4;
    run_pass("R5 settle4", 2, 3, 7, 0, 1);
    settle_cycles = 8'd1;
  endtask

  task automatic test_no_end();
    run_pass("R11 end missing", 3, 4, 2000, 0, 0);
    run_pass("R11 start missing", 0, 0, 6, 100, 0);
  endtask

  task automatic test_up_limits();
    while (e_div < VMAX || e_osc < OMAX) run_pass("R8 raise", 1, 2, 3, 0, 0);
    chk("R8 reached top", int'(div_code) == VMAX && int'(osc_code) == OMAX, div_code, VMAX);
    run_pass("R10 top hold", 1, 2, 3, 0, 0);
  endtask

  task automatic test_down_limits();
    while (e_div > 1 || e_osc > 0) run_pass("R9 lower", 0, 3, 8, 2, 0);
    chk("R9 reached bottom", int'(div_code) == 1 && int'(osc_code) == 0, div_code, 1);
    run_pass("R10 bottom hold", 0, 3, 8, 2, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_well_tuned();
    test_slow_and_fast();
    test_no_end();
    test_up_limits();
    test_down_limits();
    test_well_tuned();
    finish_run();
  end

endmodule